// File: doc/BRIEF.md
# Token Ring Receive Statistics Counters

This block keeps four management counters for the receiver of a token-ring media access controller: one for all received frames, one for error frames first seen by this station, one for frame format errors, and one for tokens. The receive state machine drives a single-cycle increment strobe for each event. Frame parsing and CRC work happen elsewhere, so those conditions arrive here as strobes.

A host processor reads a counter through a small register read port. It raises a read enable with a counter select. One clock later the port returns the value the counter held before the read, zero-extended to the bus width. The same read sets that counter back to zero. Counters wrap at their maximum and never saturate. An error strobe counts only when the incoming error indicator was not already set by an earlier station.

Top module: `tr_stat_counters`

## Requirements
- R1: After reset every counter is zero, `rd_valid` is 0 and `rd_data` is 0.
- R2: The frame counter is 16 bits and gains one for each cycle with `inc_frame` high.
- R3: The error counter is 6 bits and gains one for each cycle with `inc_err` high and `err_prev_marked` low. It is unchanged when `err_prev_marked` is high.
- R4: The lost counter is 6 bits and gains one for each cycle with `inc_lost` high.
- R5: The token counter is 16 bits and gains one for each cycle with `inc_token` high.
- R6: Each counter goes from its all-ones value to zero on the next increment.
- R7: A read (`rd_en` high) with `rd_sel` 0=frame, 1=error, 2=lost, 3=token puts the counter's pre-read value, zero-extended to 16 bits, on `rd_data` one cycle later. `rd_valid` is high in exactly that cycle.
- R8: A read sets the selected counter to zero and leaves the other three unchanged.
- R9: If an increment for a counter and a read of that same counter fall in the same cycle, the read returns the old value and the counter ends at one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| inc_frame | input | 1 | A frame was received (good or bad) |
| inc_err | input | 1 | A frame had bad CRC or invalid length |
| err_prev_marked | input | 1 | The frame's error indicator was already set upstream |
| inc_lost | input | 1 | A frame format error was seen |
| inc_token | input | 1 | A token was received |
| rd_en | input | 1 | Host read-and-clear request |
| rd_sel | input | 2 | Counter select for the read |
| rd_data | output | 16 | Read value, zero-extended |
| rd_valid | output | 1 | `rd_data` was updated by a read last cycle |

## Verification
The two functions that can meet in one cycle are an increment strobe and a host read-and-clear of the same counter. The bench raises both in one cycle, for the error counter and for others. It checks that the read returns the old value, and a follow-up read must then return one. A read of one counter during an increment of another is also provoked, to show that only the selected counter is cleared.

// File: rtl/tr_stat_pkg.sv
// Package: shared constants and select codes for the statistics counters.
// Assumes exactly four counters addressed by a two-bit select.
package tr_stat_pkg;
    localparam int NUM_CNT = 4;
    localparam int SEL_W   = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_FRAME = 2'd0,
        SEL_ERROR = 2'd1,
        SEL_LOST  = 2'd2,
        SEL_TOKEN = 2'd3
    } stat_sel_e;
endpackage

// File: rtl/tr_stat_counter.sv
// One wrapping event counter with clear-on-read.
// Assumes inc and clr are single-cycle, synchronous strobes. A clear that
// coincides with an increment leaves the count at one so the event survives.
module tr_stat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         clr,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] ONE = W'(1);

    // Count register: reset, clear (keeping a coincident event) or wrap-add.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (clr) begin
            q <= inc ? ONE : '0;
        end else if (inc) begin
            q <= q + ONE;
        end
    end
endmodule

// File: rtl/tr_stat_read_port.sv
// Host read port: selects one zero-extended counter and registers it.
// Assumes the counter values given are already widened to the bus width.
module tr_stat_read_port
    import tr_stat_pkg::*;
#(
    parameter int RD_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_en,
    input  logic [SEL_W-1:0] rd_sel,
    input  logic [RD_W-1:0] cnt_ext [NUM_CNT],
    output logic [RD_W-1:0] rd_data,
    output logic            rd_valid
);
    logic [RD_W-1:0] sel_val;

    // Pick the addressed counter value.
    always_comb begin
        sel_val = cnt_ext[rd_sel];
    end

    // Capture the pre-clear value on a read and flag it for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                rd_data <= sel_val;
            end
        end
    end
endmodule

// File: rtl/tr_stat_counters.sv
// Top: four receive statistics counters (frame, error, lost, token) with a
// read-and-clear host port. Assumes increment strobes come from the receive
// state machine, one per event, and that RD_W is at least every counter width.
module tr_stat_counters
    import tr_stat_pkg::*;
#(
    parameter int FRAME_W = 16,
    parameter int ERR_W   = 6,
    parameter int LOST_W  = 6,
    parameter int TOKEN_W = 16,
    parameter int RD_W    = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            inc_frame,
    input  logic            inc_err,
    input  logic            err_prev_marked,
    input  logic            inc_lost,
    input  logic            inc_token,
    input  logic            rd_en,
    input  logic [1:0]      rd_sel,
    output logic [RD_W-1:0] rd_data,
    output logic            rd_valid
);
    localparam int CW [NUM_CNT] = '{FRAME_W, ERR_W, LOST_W, TOKEN_W};

    logic [NUM_CNT-1:0] inc_vec;
    logic [NUM_CNT-1:0] clr_vec;
    logic [RD_W-1:0]    cnt_ext [NUM_CNT];

    // Gather increment requests; an error counts only if not flagged upstream.
    always_comb begin
        inc_vec[SEL_FRAME] = inc_frame;
        inc_vec[SEL_ERROR] = inc_err & ~err_prev_marked;
        inc_vec[SEL_LOST]  = inc_lost;
        inc_vec[SEL_TOKEN] = inc_token;
    end

    genvar gi;
    generate
        for (gi = 0; gi < NUM_CNT; gi++) begin : g_cnt
            logic [CW[gi]-1:0] q;

            // Clear request for this counter from the host read.
            assign clr_vec[gi] = rd_en && (rd_sel == SEL_W'(gi));

            tr_stat_counter #(.W(CW[gi])) i_cnt (
                .clk   (clk),
                .rst_n (rst_n),
                .inc   (inc_vec[gi]),
                .clr   (clr_vec[gi]),
                .q     (q)
            );

            assign cnt_ext[gi] = RD_W'(q);
        end
    endgenerate

    tr_stat_read_port #(.RD_W(RD_W)) i_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .rd_sel   (rd_sel),
        .cnt_ext  (cnt_ext),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );
endmodule

// File: rtl/tr_stat_counters_chk.sv
// Checker for tr_stat_counters, bound to every instance of the top module.
module tr_stat_counters_chk #(
    parameter int RD_W   = 16,
    parameter int LOST_W = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            inc_frame,
    input logic            inc_err,
    input logic            err_prev_marked,
    input logic            inc_lost,
    input logic            rd_en,
    input logic [1:0]      rd_sel,
    input logic [RD_W-1:0] rd_data,
    input logic            rd_valid,
    input logic [RD_W-1:0] cnt_frame,
    input logic [RD_W-1:0] cnt_err,
    input logic [RD_W-1:0] cnt_lost
);
    localparam logic [RD_W-1:0] LOST_MAX = RD_W'((1 << LOST_W) - 1);

    // R7
    rd_valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);
    // R7
    rd_valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);
    // R7
    rd_frame_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_sel == 2'd0) |=> rd_data == $past(cnt_frame));
    // R2
    frame_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_frame && !(rd_en && rd_sel == 2'd0)) |=> cnt_frame == RD_W'($past(cnt_frame) + 1'b1));
    // R3
    err_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_err && err_prev_marked && !(rd_en && rd_sel == 2'd1)) |=> $stable(cnt_err));
    // R6
    lost_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_lost && cnt_lost == LOST_MAX && !(rd_en && rd_sel == 2'd2)) |=> cnt_lost == '0);
    // R8
    frame_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_sel == 2'd0 && !inc_frame) |=> cnt_frame == '0);
    // R9
    frame_coincide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_sel == 2'd0 && inc_frame) |=> cnt_frame == RD_W'(1));
endmodule

bind tr_stat_counters tr_stat_counters_chk #(.RD_W(RD_W), .LOST_W(LOST_W)) i_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .inc_frame       (inc_frame),
    .inc_err         (inc_err),
    .err_prev_marked (err_prev_marked),
    .inc_lost        (inc_lost),
    .rd_en           (rd_en),
    .rd_sel          (rd_sel),
    .rd_data         (rd_data),
    .rd_valid        (rd_valid),
    .cnt_frame       (cnt_ext[0]),
    .cnt_err         (cnt_ext[1]),
    .cnt_lost        (cnt_ext[2])
);

// File: tb/test_tr_stat_counters.sv
module test_tr_stat_counters;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        inc_frame = 1'b0, inc_err = 1'b0, err_prev_marked = 1'b0;
    logic        inc_lost = 1'b0, inc_token = 1'b0, rd_en = 1'b0;
    logic [1:0]  rd_sel = 2'd0;
    logic [15:0] rd_data;
    logic        rd_valid;
    int          total = 0;
    int          bad = 0;

    always #4 clk = ~clk;

    tr_stat_counters i_tr_stat_counters (
        .clk(clk), .rst_n(rst_n), .inc_frame(inc_frame), .inc_err(inc_err),
        .err_prev_marked(err_prev_marked), .inc_lost(inc_lost),
        .inc_token(inc_token), .rd_en(rd_en), .rd_sel(rd_sel),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    // Vector: inc mask {token,lost,err,frame}, prev mark, read, sel, expected read value
    localparam int NV = 14;
    localparam logic [23:0] VEC [NV] = '{
        {4'b1001, 1'b0, 1'b0, 2'd0, 16'd0},   // frame, token
        {4'b0011, 1'b0, 1'b0, 2'd0, 16'd0},   // frame, error counted
        {4'b0010, 1'b1, 1'b0, 2'd0, 16'd0},   // error already marked: ignored (R3)
        {4'b0100, 1'b0, 1'b0, 2'd0, 16'd0},   // lost
        {4'b0101, 1'b0, 1'b0, 2'd0, 16'd0},   // frame, lost
        {4'b0000, 1'b0, 1'b1, 2'd0, 16'd3},   // read frame (R2)
        {4'b0000, 1'b0, 1'b1, 2'd1, 16'd1},   // read error (R3)
        {4'b0000, 1'b0, 1'b1, 2'd2, 16'd2},   // read lost (R4)
        {4'b0000, 1'b0, 1'b1, 2'd3, 16'd1},   // read token (R5)
        {4'b0000, 1'b0, 1'b1, 2'd0, 16'd0},   // frame cleared by read (R8)
        {4'b0010, 1'b0, 1'b1, 2'd1, 16'd0},   // error inc with read (R9)
        {4'b0000, 1'b0, 1'b1, 2'd1, 16'd1},   // keeps the event (R9)
        {4'b1000, 1'b0, 1'b1, 2'd0, 16'd0},   // token inc while reading frame (R8)
        {4'b0000, 1'b0, 1'b1, 2'd3, 16'd1}    // token untouched by frame read (R8)
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one cycle of inputs at the falling edge, sample at the next one.
    task automatic cyc(input logic [3:0] inc, input logic mark, input logic rd,
                       input logic [1:0] sel);
        inc_frame = inc[0]; inc_err = inc[1]; inc_lost = inc[2]; inc_token = inc[3];
        err_prev_marked = mark; rd_en = rd; rd_sel = sel;
        @(negedge clk);
        inc_frame = 0; inc_err = 0; inc_lost = 0; inc_token = 0;
        err_prev_marked = 0; rd_en = 0;
    endtask

    task automatic rd_chk(input string req, input logic [1:0] sel, input logic [15:0] exp);
        cyc(4'b0000, 1'b0, 1'b1, sel);
        check(req, rd_data, exp);
        check({req, " valid"}, 16'(rd_valid), 16'd1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 rd_data", rd_data, 16'd0);
        check("R1 rd_valid", 16'(rd_valid), 16'd0);
        rd_chk("R1 frame", 2'd0, 16'd0);
        rd_chk("R1 token", 2'd3, 16'd0);

        for (int i = 0; i < NV; i++) begin
            cyc(VEC[i][23:20], VEC[i][19], VEC[i][18], VEC[i][17:16]);
            if (VEC[i][18]) begin
                check($sformatf("R7 vector %0d", i), rd_data, VEC[i][15:0]);
                check("R7 valid", 16'(rd_valid), 16'd1);
            end
        end
        cyc(4'b0000, 1'b0, 1'b0, 2'd0);
        check("R7 valid idle", 16'(rd_valid), 16'd0);

        // R6 6-bit counters: 63 increments then error read, lost wraps on the 64th
        for (int i = 0; i < 63; i++) cyc(4'b0110, 1'b0, 1'b0, 2'd0);
        rd_chk("R6 error max", 2'd1, 16'd63);
        cyc(4'b0100, 1'b0, 1'b0, 2'd0);
        rd_chk("R6 lost wrap", 2'd2, 16'd0);

        // R6 16-bit counters: 65535 increments, then token wraps on one more
        for (int i = 0; i < 65535; i++) cyc(4'b1001, 1'b0, 1'b0, 2'd0);
        rd_chk("R6 frame max", 2'd0, 16'hFFFF);
        cyc(4'b1000, 1'b0, 1'b0, 2'd0);
        rd_chk("R6 token wrap", 2'd3, 16'd0);

        // R1 reset mid-run clears counts
        cyc(4'b0001, 1'b0, 1'b0, 2'd0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 rd_valid after reset", 16'(rd_valid), 16'd0);
        rd_chk("R1 frame after reset", 2'd0, 16'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule